// File: doc/BRIEF.md
# Snapshot Counter with Latch and Clear Commands

A free-running counter whose width is twice the register width (64 bits by default) advances by one on every clock cycle in which its tick-enable input is high, and rolls over from all ones to zero. Software does not see the live count. It sees a snapshot held in a low and a high register. A write to the control register with the capture command bit set copies the running count into the snapshot. A write with the zero command bit set clears the snapshot. Both command bits clear themselves in the same write, so they always read back as zero.

Software may also write the low and high snapshot registers directly. The control register keeps every other bit written to it, and those bits have no effect. Register reads are combinational from the address input. Writes take effect on the next rising clock edge.

Top module: `snap_counter`

## Requirements
- R1: After reset, the control, low and high registers all read zero, and the running count is zero.
- R2: The running count increases by one at each clock edge where tick_i is high. It holds its value when tick_i is low, and it wraps from all ones to zero.
- R3: A control write with bit 1 (capture) set and bit 0 clear loads the low register with count bits [REG_W-1:0] and the high register with count bits [2*REG_W-1:REG_W]. The value loaded is the count present in the write cycle, before any increment that happens at the same edge.
- R4: A control write with bit 0 (clear) set loads zero into both the low and high registers.
- R5: When bits 1 and 0 are both set in one control write, the capture is applied first and the clear second, so both registers end at zero.
- R6: The control register reads back the last written value with bits 1 and 0 forced to zero. Its other bits change neither the snapshot nor the count.
- R7: A write to address 1 loads the low register, and a write to address 2 loads the high register. Each write leaves the other register unchanged.
- R8: Register map: address 0 is control, address 1 is low, address 2 is high. Address 3 reads zero, and writes to it change no register.
- R9: rdata_o shows the register selected by addr_i in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for the running counter |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address, used for both read and write |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Read data of the register selected by addr_i |

## Verification
The bench builds two copies of the block that share the same inputs. The first uses the default REG_W of 32. It covers the full 32-bit register paths, direct writes, the command bits and capture timing against a count that the bench tracks tick by tick. The second uses REG_W of 4, which gives an 8-bit counter. That copy wraps within a few hundred ticks, so the rollover and the placement of the upper count bits in the high register can be checked; neither is reachable with a 64-bit count.

// File: rtl/snap_counter_pkg.sv
package snap_counter_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  localparam int unsigned CAPTURE_BIT = 1;
  localparam int unsigned ZERO_BIT    = 0;
  localparam int unsigned NUM_HALVES  = 2;
endpackage

// File: rtl/snap_free_cnt.sv
module snap_free_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/snap_cmd_decode.sv
module snap_cmd_decode
  import snap_counter_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic                  wr_en_i,
  input  logic [1:0]            addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic                  ctrl_we_o,
  output logic [REG_W-1:0]      ctrl_d_o,
  output logic                  capture_o,
  output logic                  zero_o,
  output logic [NUM_HALVES-1:0] half_we_o
);
  always_comb begin
    ctrl_we_o = wr_en_i && (addr_i == ADDR_CTRL);
    ctrl_d_o  = wdata_i;
    ctrl_d_o[CAPTURE_BIT] = 1'b0;  // self-clearing commands
    ctrl_d_o[ZERO_BIT]    = 1'b0;
    capture_o = ctrl_we_o && wdata_i[CAPTURE_BIT];
    zero_o    = ctrl_we_o && wdata_i[ZERO_BIT];
    half_we_o[0] = wr_en_i && (addr_i == ADDR_LO);
    half_we_o[1] = wr_en_i && (addr_i == ADDR_HI);
  end
endmodule

// File: rtl/snap_regs.sv
module snap_regs
  import snap_counter_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  localparam int unsigned CNT_W = NUM_HALVES * REG_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  capture_i,
  input  logic                  zero_i,
  input  logic [NUM_HALVES-1:0] half_we_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [CNT_W-1:0]      snap_o
);
  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    logic [REG_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           half_q <= '0;
      else if (zero_i)       half_q <= '0;   // clear wins over capture
      else if (capture_i)    half_q <= cnt_i[g*REG_W +: REG_W];
      else if (half_we_i[g]) half_q <= wdata_i;
    end
    assign snap_o[g*REG_W +: REG_W] = half_q;
  end
endmodule

// File: rtl/snap_counter.sv
module snap_counter
  import snap_counter_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = NUM_HALVES * REG_W;

  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      snap;
  logic [REG_W-1:0]      ctrl_q;
  logic [REG_W-1:0]      ctrl_d;
  logic                  ctrl_we;
  logic                  capture;
  logic                  zero;
  logic [NUM_HALVES-1:0] half_we;

  snap_free_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt)
  );

  snap_cmd_decode #(.REG_W(REG_W)) i_dec (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ctrl_we_o(ctrl_we),
    .ctrl_d_o (ctrl_d),
    .capture_o(capture),
    .zero_o   (zero),
    .half_we_o(half_we)
  );

  snap_regs #(.REG_W(REG_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .capture_i(capture),
    .zero_i   (zero),
    .half_we_i(half_we),
    .wdata_i  (wdata_i),
    .snap_o   (snap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_LO:   rdata_o = snap[REG_W-1:0];
      ADDR_HI:   rdata_o = snap[CNT_W-1:REG_W];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/snap_counter_chk.sv
module snap_counter_chk #(
  parameter int unsigned REG_W = 32,
  localparam int unsigned CNT_W = 2 * REG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] snap,
  input logic [REG_W-1:0] ctrl_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == 2'd0);

  // R1
  always_comb if (!rst_ni) rst_zero_chk: assert (cnt == '0 && snap == '0 && ctrl_q == '0);

  // R2
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt == $past(cnt) + 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt));

  // R3
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[1] && !wdata_i[0]) |=> snap == $past(cnt));

  // R4
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[0]) |=> snap == '0);

  // R6
  ctrl_rb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl_q == {$past(wdata_i[REG_W-1:2]), 2'b00});

  // R7
  lo_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> snap[REG_W-1:0] == $past(wdata_i)
                                    && $stable(snap[CNT_W-1:REG_W]));

  // R8
  rsvd_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3) |=> $stable(snap) && $stable(ctrl_q));
endmodule

bind snap_counter snap_counter_chk #(.REG_W(REG_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .cnt    (cnt),
  .snap   (snap),
  .ctrl_q (ctrl_q)
);

// File: tb/test_snap_counter.sv
`timescale 1ns/1ps
module test_snap_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  rdata_s;

  int checks = 0;
  int fails = 0;
  longint unsigned mcnt = 0;   // model running count
  logic [63:0] msnap = '0;     // model snapshot, main copy
  logic [7:0]  msnap_s = '0;   // model snapshot, small copy

  always #2.5 clk = ~clk;

  snap_counter #(.REG_W(32)) i_snap_counter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  snap_counter #(.REG_W(4)) i_snap_counter_s (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata[3:0]), .rdata_o(rdata_s));

  // {wr, addr, data, expected read}
  localparam logic [66:0] VEC [10] = '{
    {1'b1, 2'd1, 32'hDEADBEEF, 32'h0},
    {1'b0, 2'd1, 32'h0, 32'hDEADBEEF},
    {1'b0, 2'd2, 32'h0, 32'h0},
    {1'b1, 2'd2, 32'h12345678, 32'h0},
    {1'b0, 2'd2, 32'h0, 32'h12345678},
    {1'b0, 2'd1, 32'h0, 32'hDEADBEEF},
    {1'b1, 2'd3, 32'hFFFFFFFF, 32'h0},
    {1'b0, 2'd3, 32'h0, 32'h0},
    {1'b0, 2'd1, 32'h0, 32'hDEADBEEF},
    {1'b0, 2'd0, 32'h0, 32'h0}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycle(logic w, logic [1:0] a, logic [31:0] d, logic t);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    if (w && a == 2'd0) begin
      if (d[1]) begin msnap = mcnt; msnap_s = mcnt[7:0]; end
      if (d[0]) begin msnap = '0; msnap_s = '0; end
    end
    if (w && a == 2'd1) msnap[31:0] = d;
    if (w && a == 2'd2) msnap[63:32] = d;
    if (t) mcnt++;
  endtask

  task automatic rd(logic [1:0] a);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; addr = a;
    #1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0); check("R1 ctrl", rdata, 32'h0);
    rd(2'd1); check("R1 lo", rdata, 32'h0);
    rd(2'd2); check("R1 hi", rdata, 32'h0);

    // R7 R8 R9 table walk
    foreach (VEC[i]) begin
      if (VEC[i][66]) cycle(1'b1, VEC[i][65:64], VEC[i][63:32], 1'b0);
      else begin
        rd(VEC[i][65:64]);
        check($sformatf("R7/R8/R9 vec %0d", i), rdata, VEC[i][31:0]);
      end
    end

    // R2 R3: count 10 ticks, capture
    for (int k = 0; k < 10; k++) cycle(1'b0, 2'd0, '0, 1'b1);
    cycle(1'b1, 2'd0, 32'h2, 1'b0);
    rd(2'd1); check("R3 lo after capture", rdata, 32'd10);
    rd(2'd2); check("R3 hi after capture", rdata, 32'd0);
    rd(2'd0); check("R6 capture bit self-clears", rdata, 32'h0);

    // R2 hold: idle cycles then capture
    for (int k = 0; k < 5; k++) cycle(1'b0, 2'd0, '0, 1'b0);
    cycle(1'b1, 2'd0, 32'h2, 1'b0);
    rd(2'd1); check("R2 count holds without tick", rdata, 32'd10);

    // R3 capture in a tick cycle takes the pre-increment value
    cycle(1'b1, 2'd0, 32'h2, 1'b1);
    rd(2'd1); check("R3 capture pre-increment", rdata, msnap[31:0]);
    check("R3 model agrees", msnap[31:0], 32'd10);
    cycle(1'b1, 2'd0, 32'h2, 1'b0);
    rd(2'd1); check("R2 tick counted", rdata, 32'd11);

    // R4 clear
    cycle(1'b1, 2'd1, 32'hA5A5A5A5, 1'b0);
    cycle(1'b1, 2'd2, 32'h5A5A5A5A, 1'b0);
    cycle(1'b1, 2'd0, 32'h1, 1'b0);
    rd(2'd1); check("R4 lo cleared", rdata, 32'h0);
    rd(2'd2); check("R4 hi cleared", rdata, 32'h0);

    // R5 both bits
    cycle(1'b1, 2'd0, 32'h2, 1'b0);
    rd(2'd1); check("R5 nonzero before", rdata, 32'd11);
    cycle(1'b1, 2'd0, 32'h3, 1'b1);
    rd(2'd1); check("R5 lo zero", rdata, 32'h0);
    rd(2'd2); check("R5 hi zero", rdata, 32'h0);
    rd(2'd0); check("R5 ctrl reads zero low bits", rdata, 32'h0);

    // R6 other control bits stored, no effect
    cycle(1'b1, 2'd1, 32'h00C0FFEE, 1'b0);
    cycle(1'b1, 2'd0, 32'hF0F0F0FC, 1'b0);
    rd(2'd0); check("R6 ctrl readback", rdata, 32'hF0F0F0FC);
    rd(2'd1); check("R6 snapshot untouched", rdata, 32'h00C0FFEE);

    // R2 wrap and R3 high half on the small copy (8-bit count)
    cycle(1'b1, 2'd0, 32'h1, 1'b0);
    for (int k = 0; k < 300; k++) cycle(1'b0, 2'd0, '0, 1'b1);
    cycle(1'b1, 2'd0, 32'h2, 1'b0);
    rd(2'd1); check("R2 wrap small lo", {28'h0, rdata_s}, {28'h0, msnap_s[3:0]});
    rd(2'd2); check("R3 wrap small hi", {28'h0, rdata_s}, {28'h0, msnap_s[7:4]});
    check("R2 wrapped model", {24'h0, msnap_s}, 32'((mcnt) % 256));
    rd(2'd1); check("R3 main lo", rdata, msnap[31:0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule